// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block performs one register access over a two-wire serial debug link: a read or a write of a debug-port or access-port register. A request arrives on a valid/ready command port with the direction, the port select, a two-bit register address and 32 bits of write data. The engine then generates the serial clock and drives or releases the bidirectional data line bit by bit. It sends the 8-bit request header, lets the line turn around, samples the target's 3-bit acknowledge, and then moves a 32-bit data word plus parity in the direction the request called for. The transaction closes with eight low idle bits. After that, one response comes out on a valid/ready result port: the acknowledge code, the read data and a read-parity error flag.

Requests and responses follow valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no transaction is running and no response is waiting. A response stays on `rsp_*` with `rsp_valid` high until a clock edge where `rsp_ready` is high. While the consumer holds `rsp_ready` low, new requests are refused, so the block never holds more than one operation. The turnaround length and the clock divider are plain configuration inputs. They are captured on the same edge that accepts the request.

Top module: `swd_host`

## Requirements
- R1: The header goes out in wire order bit 0 to bit 7 as follows: 1, port select (1 = access port), direction (1 = read), address bit 0, address bit 1, a parity bit that is 1 when an odd number of the four bits just listed are 1, then 0. For the eighth bit `swdio_oe` is 0.
- R2: Right after the header, the host holds `swdio_oe` at 0 for `cfg_trn`+1 bit periods. It also keeps `swdio_oe` at 0 for the three acknowledge bits and for a second turnaround of the same length. Host and target never drive the line at the same time.
- R3: The acknowledge is three bits sampled on the line. The first bit received lands in `rsp_ack[0]`, so OK is 3'b001.
- R4: Any acknowledge other than 3'b001 skips the data phase. The transaction is then 8+T+3+T+8 bit periods long, where T = `cfg_trn`+1, and `rsp_rdata` and `rsp_perr` report 0.
- R5: A read that is acknowledged OK samples 32 data bits, least significant first, directly after the acknowledge, followed by one parity bit. The word is reported on `rsp_rdata`, and the transaction is 8+T+3+33+T+8 bit periods long.
- R6: On an OK read, `rsp_perr` is 1 exactly when the received parity bit differs from the XOR of the 32 received data bits (even parity).
- R7: An OK write drives 32 bits of `req_wdata`, least significant first, after the second turnaround, then the XOR of those bits, with `swdio_oe` at 1. The transaction is 8+T+3+T+33+8 bit periods long.
- R8: Every transaction ends with 8 bit periods in which the host drives the line low.
- R9: `swdio_out` and `swdio_oe` change only when `swclk` falls, or when a request is accepted. Received bits are sampled as `swclk` rises.
- R10: Each phase of `swclk`, high and low, lasts `cfg_div`+1 system clocks. `swclk` stays low while idle.
- R11: `req_ready` is 0 while a transaction runs or a response is pending. A pending response holds its values until it is taken. A change to `cfg_trn` or `cfg_div` after acceptance does not affect the running transaction.
- R12: After reset, `req_ready` is 1, `rsp_valid` is 0, `swclk` is 0 and `swdio_oe` is 0. The line stays released whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | SWCLK half period minus one, in system clocks |
| cfg_trn | input | TRN_W | Turnaround length minus one, in bit periods |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_ack | output | 3 | Acknowledge, first wire bit in bit 0 |
| rsp_rdata | output | DATA_W | Read data, 0 unless OK read |
| rsp_perr | output | 1 | Read parity mismatch |
| swclk | output | 1 | Serial debug clock |
| swdio_out | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | Data line drive enable |
| swdio_in | input | 1 | Data line as seen at the pin |

## Verification
The hardest case to reach is a read with a corrupted parity bit whose data word has every bit set. The data must arrive correctly while the parity check fails, so the target model has to complete the full acknowledge and data exchange and then invert only the final bit it drives. The bench's target model decodes bit positions from the observed `swclk` edges and the turnaround length it was given. An inversion flag set by the driver corrupts exactly that last bit. The same transaction also holds the response back and changes the configuration inputs in flight, so that R6 and R11 are exercised together.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_TRN1,
    PH_ACK,
    PH_RD,
    PH_TRN2,
    PH_WR,
    PH_TAIL
  } phase_e;

  localparam logic [2:0] ACK_OK = 3'b001;

  // Header byte in wire order (bit 0 first): start, port, dir, a0, a1, parity, stop, park
  function automatic logic [7:0] hdr_byte(logic ap, logic rd, logic [1:0] a);
    return {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  output logic             swclk,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic             hi;
  logic             at_end;

  assign at_end = (cnt == div_q);
  assign rise   = run && !hi && at_end;
  assign fall   = run &&  hi && at_end;
  assign swclk  = hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
      hi    <= 1'b0;
    end else begin
      if (start) div_q <= div;
      if (!run) begin
        cnt <= '0;
        hi  <= 1'b0;
      end else if (at_end) begin
        cnt <= '0;
        hi  <= ~hi;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_pkg::*;
#(
  parameter int TRN_W     = 2,
  parameter int DATA_W    = 32,
  parameter int TAIL_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRN_W-1:0]  cfg_trn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_ap,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  input  logic              rise,
  input  logic              fall,
  output logic              run,
  output logic              start,
  input  logic              swdio_in,
  output logic              swdio_out,
  output logic              swdio_oe
);

  localparam int CNT_W = $clog2(DATA_W + TAIL_BITS + (1 << TRN_W) + 8);

  phase_e            ph;
  logic [CNT_W-1:0]  bcnt;
  logic [CNT_W-1:0]  last;
  logic [TRN_W-1:0]  trn_q;
  logic              rd_q;
  logic [7:0]        hdr_sh;
  logic [DATA_W:0]   wr_sh;
  logic [DATA_W:0]   rd_sh;
  logic [2:0]        ack_sh;
  logic              ack_ok;

  assign req_ready = (ph == PH_IDLE) && !rsp_valid;
  assign start     = req_valid && req_ready;
  assign run       = (ph != PH_IDLE);
  assign ack_ok    = (ack_sh == ACK_OK);

  always_comb begin
    case (ph)
      PH_HDR:          last = CNT_W'(7);
      PH_TRN1, PH_TRN2: last = CNT_W'(trn_q);
      PH_ACK:          last = CNT_W'(2);
      PH_RD, PH_WR:    last = CNT_W'(DATA_W);
      PH_TAIL:         last = CNT_W'(TAIL_BITS - 1);
      default:         last = '0;
    endcase
  end

  always_comb begin
    swdio_oe  = 1'b0;
    swdio_out = 1'b0;
    case (ph)
      PH_HDR: begin
        swdio_oe  = (bcnt != CNT_W'(7));
        swdio_out = hdr_sh[0];
      end
      PH_WR: begin
        swdio_oe  = 1'b1;
        swdio_out = wr_sh[0];
      end
      PH_TAIL: swdio_oe = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      bcnt      <= '0;
      trn_q     <= '0;
      rd_q      <= 1'b0;
      hdr_sh    <= '0;
      wr_sh     <= '0;
      rd_sh     <= '0;
      ack_sh    <= '0;
      rsp_valid <= 1'b0;
      rsp_ack   <= '0;
      rsp_rdata <= '0;
      rsp_perr  <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (start) begin
        ph     <= PH_HDR;
        bcnt   <= '0;
        trn_q  <= cfg_trn;
        rd_q   <= req_read;
        hdr_sh <= hdr_byte(req_ap, req_read, req_addr);
        wr_sh  <= {^req_wdata, req_wdata};
      end
      if (rise) begin
        if (ph == PH_ACK) ack_sh <= {swdio_in, ack_sh[2:1]};
        if (ph == PH_RD)  rd_sh  <= {swdio_in, rd_sh[DATA_W:1]};
      end
      if (fall) begin
        if (ph == PH_HDR) hdr_sh <= hdr_sh >> 1;
        if (ph == PH_WR)  wr_sh  <= wr_sh >> 1;
        if (bcnt != last) begin
          bcnt <= bcnt + 1'b1;
        end else begin
          bcnt <= '0;
          case (ph)
            PH_HDR:  ph <= PH_TRN1;
            PH_TRN1: ph <= PH_ACK;
            PH_ACK:  ph <= (ack_ok && rd_q) ? PH_RD : PH_TRN2;
            PH_RD:   ph <= PH_TRN2;
            PH_TRN2: ph <= (ack_ok && !rd_q) ? PH_WR : PH_TAIL;
            PH_WR:   ph <= PH_TAIL;
            PH_TAIL: begin
              ph        <= PH_IDLE;
              rsp_valid <= 1'b1;
              rsp_ack   <= ack_sh;
              rsp_rdata <= (ack_ok && rd_q) ? rd_sh[DATA_W-1:0] : '0;
              rsp_perr  <= ack_ok && rd_q && ((^rd_sh[DATA_W-1:0]) != rd_sh[DATA_W]);
            end
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/swd_host.sv
module swd_host #(
  parameter int DIV_W     = 8,
  parameter int TRN_W     = 2,
  parameter int DATA_W    = 32,
  parameter int TAIL_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [TRN_W-1:0]  cfg_trn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_ap,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  output logic              swclk,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in
);

  logic run;
  logic start;
  logic rise;
  logic fall;

  swd_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .div   (cfg_div),
    .run   (run),
    .swclk (swclk),
    .rise  (rise),
    .fall  (fall)
  );

  swd_seq #(.TRN_W(TRN_W), .DATA_W(DATA_W), .TAIL_BITS(TAIL_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_trn   (cfg_trn),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_read  (req_read),
    .req_ap    (req_ap),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_ack   (rsp_ack),
    .rsp_rdata (rsp_rdata),
    .rsp_perr  (rsp_perr),
    .rise      (rise),
    .fall      (fall),
    .run       (run),
    .start     (start),
    .swdio_in  (swdio_in),
    .swdio_out (swdio_out),
    .swdio_oe  (swdio_oe)
  );

endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              swclk,
  input logic              swdio_out,
  input logic              swdio_oe,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [2:0]        rsp_ack,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_perr
);

  p_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));

  p_idle_clk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !swclk);

  p_no_take_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack) &&
                                   $stable(rsp_rdata) && $stable(rsp_perr)));

  p_perr_ok_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ack != 3'b001) |-> !rsp_perr);

  p_idle_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !swdio_oe);

endmodule

bind swd_host swd_host_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .swclk     (swclk),
  .swdio_out (swdio_out),
  .swdio_oe  (swdio_oe),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_ack   (rsp_ack),
  .rsp_rdata (rsp_rdata),
  .rsp_perr  (rsp_perr)
);

// File: tb/swd_host_tb.sv
module swd_host_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic [1:0]  cfg_trn = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_read = 1'b0;
  logic        req_ap = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        rsp_perr;
  logic        swclk;
  logic        swdio_out;
  logic        swdio_oe;
  logic        swdio_in;

  logic        tgt_oe = 1'b0;
  logic        tgt_val = 1'b0;

  assign swdio_in = swdio_oe ? swdio_out : (tgt_oe ? tgt_val : 1'b1);

  always #10 clk = ~clk;

  swd_host u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_trn(cfg_trn),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_ap(req_ap), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .swclk(swclk),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  typedef struct {
    logic [7:0]  hdr;
    logic        rd;
    logic        ok;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic [31:0] wdata;
    logic        perr;
    int          trn;
    int          nbits;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int done_cnt = 0;

  // target model settings written by the driver
  logic [2:0]  tgt_ack = 3'b001;
  logic [31:0] tgt_rdata = '0;
  logic        tgt_bad = 1'b0;
  logic        tgt_rd = 1'b0;
  int          tgt_trn = 1;
  int          cur_div = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // target model + monitor, all sampled on the falling system clock edge
  logic [63:0] hb, ho;
  int          bitn, hicnt, aidx, bidx, cidx, didx;
  logic        pswclk, pso, poe, hibad, clash, midchg, okb;
  exp_t        e;

  always @(negedge clk) begin
    if (!rst_n) begin
      bitn = 0; hicnt = 0; pswclk = 0; pso = 0; poe = 0;
      hibad = 0; clash = 0; midchg = 0; tgt_oe <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        bitn = 0; hicnt = 0; hibad = 0; clash = 0; midchg = 0;
        hb = '0; ho = '0;
      end
      if (swdio_oe && tgt_oe) clash = 1;
      if (swclk && pswclk && (swdio_out != pso || swdio_oe != poe)) midchg = 1;
      if (swclk) hicnt++;
      if (swclk && !pswclk) begin
        if (bitn < 64) begin hb[bitn] = swdio_out; ho[bitn] = swdio_oe; end
        bitn++;
      end
      if (!swclk && pswclk) begin
        if (hicnt != cur_div + 1) hibad = 1;
        hicnt = 0;
        aidx = 8 + tgt_trn;
        if (bitn >= aidx && bitn < aidx + 3) begin
          tgt_oe <= 1'b1; tgt_val <= tgt_ack[bitn - aidx];
        end else if (tgt_ack == 3'b001 && tgt_rd && bitn >= aidx + 3 && bitn < aidx + 35) begin
          tgt_oe <= 1'b1; tgt_val <= tgt_rdata[bitn - aidx - 3];
        end else if (tgt_ack == 3'b001 && tgt_rd && bitn == aidx + 35) begin
          tgt_oe <= 1'b1; tgt_val <= (^tgt_rdata) ^ tgt_bad;
        end else begin
          tgt_oe <= 1'b0;
        end
      end
      pswclk = swclk; pso = swdio_out; poe = swdio_oe;

      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11", "unexpected response", 64'd1, 64'd0);
        end else begin
          e = q.pop_front();
          aidx = 8 + e.trn;
          bidx = aidx + 3 + ((e.ok && e.rd) ? 33 : 0);
          cidx = aidx + 3 + e.trn;
          didx = e.nbits - 8;
          okb = 1;
          for (int i = 0; i < 7; i++) if (hb[i] !== e.hdr[i] || ho[i] !== 1'b1) okb = 0;
          if (ho[7] !== 1'b0) okb = 0;
          chk(okb, "R1", "header bits", hb[7:0], {1'b0, e.hdr[6:0]});
          okb = !clash;
          for (int i = 8; i < aidx + 3; i++) if (ho[i] !== 1'b0) okb = 0;
          for (int i = bidx; i < bidx + e.trn; i++) if (ho[i] !== 1'b0) okb = 0;
          chk(okb, "R2", "turnaround release", ho, 64'd0);
          chk(rsp_ack === e.ack, "R3", "ack code", 64'(rsp_ack), 64'(e.ack));
          chk(bitn == e.nbits, e.ok ? (e.rd ? "R5" : "R7") : "R4", "bit count",
              64'(bitn), 64'(e.nbits));
          chk(rsp_rdata === e.rdata, e.ok ? "R5" : "R4", "read data",
              64'(rsp_rdata), 64'(e.rdata));
          chk(rsp_perr === e.perr, "R6", "parity flag", 64'(rsp_perr), 64'(e.perr));
          if (e.ok && !e.rd) begin
            okb = 1;
            for (int i = 0; i < 32; i++)
              if (hb[cidx + i] !== e.wdata[i] || ho[cidx + i] !== 1'b1) okb = 0;
            if (hb[cidx + 32] !== ^e.wdata || ho[cidx + 32] !== 1'b1) okb = 0;
            chk(okb, "R7", "write data on line", hb >> cidx, 64'({^e.wdata, e.wdata}));
          end
          okb = 1;
          for (int i = didx; i < e.nbits; i++) if (hb[i] !== 1'b0 || ho[i] !== 1'b1) okb = 0;
          chk(okb, "R8", "tail idle low", ho >> didx, 64'hff);
          chk(!midchg, "R9", "line change while clock high", 64'(midchg), 64'd0);
          chk(!hibad, "R10", "clock phase length", 64'(hibad), 64'd0);
        end
        done_cnt++;
      end
    end
  end

  task automatic issue(input logic rd, input logic ap, input logic [1:0] a,
                       input logic [31:0] wd, input logic [2:0] ack,
                       input logic [31:0] rdat, input logic bad,
                       input int trn, input int div,
                       input logic hold, input logic chcfg);
    exp_t x;
    int   prev;
    logic acc;
    prev = done_cnt;
    cfg_trn = 2'(trn - 1);
    cfg_div = 8'(div);
    tgt_ack = ack; tgt_rdata = rdat; tgt_bad = bad; tgt_rd = rd;
    tgt_trn = trn; cur_div = div;
    x.hdr   = {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
    x.rd    = rd;
    x.ok    = (ack == 3'b001);
    x.ack   = ack;
    x.rdata = (x.ok && rd) ? rdat : 32'd0;
    x.wdata = wd;
    x.perr  = x.ok && rd && bad;
    x.trn   = trn;
    x.nbits = 8 + trn + 3 + trn + 8 + (x.ok ? 33 : 0);
    q.push_back(x);
    if (hold) rsp_ready = 1'b0;
    req_read = rd; req_ap = ap; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 1'b0;
    if (chcfg) begin
      cfg_trn = ~cfg_trn;
      cfg_div = cfg_div + 8'd2;
    end
    if (hold) begin
      do @(negedge clk); while (!rsp_valid);
      repeat (4) @(negedge clk);
      chk(rsp_valid && !req_ready, "R11", "response held, request refused",
          {62'd0, rsp_valid, req_ready}, 64'd2);
      @(posedge clk); #1;
      rsp_ready = 1'b1;
    end
    while (done_cnt == prev) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !swclk && !swdio_oe, "R12", "reset state",
        {60'd0, req_ready, rsp_valid, swclk, swdio_oe}, 64'h8);
    @(posedge clk); #1;
    issue(1'b1, 1'b0, 2'd0, 32'd0,        3'b001, 32'h2BA01477, 1'b0, 1, 1, 1'b0, 1'b0);
    issue(1'b0, 1'b1, 2'd1, 32'hDEADBEEF, 3'b001, 32'd0,        1'b0, 2, 0, 1'b0, 1'b0);
    issue(1'b1, 1'b1, 2'd3, 32'd0,        3'b010, 32'h12345678, 1'b0, 3, 2, 1'b0, 1'b0);
    issue(1'b0, 1'b0, 2'd2, 32'hA5A5A5A5, 3'b100, 32'd0,        1'b0, 4, 0, 1'b0, 1'b0);
    issue(1'b1, 1'b1, 2'd2, 32'd0,        3'b001, 32'h80000001, 1'b1, 1, 0, 1'b0, 1'b0);
    issue(1'b1, 1'b0, 2'd1, 32'd0,        3'b001, 32'hFFFFFFFF, 1'b1, 2, 3, 1'b1, 1'b1);
    issue(1'b1, 1'b0, 2'd0, 32'd0,        3'b111, 32'h0000FFFF, 1'b0, 1, 1, 1'b0, 1'b0);
    issue(1'b0, 1'b1, 2'd3, 32'h00000001, 3'b001, 32'd0,        1'b0, 3, 1, 1'b0, 1'b1);
    @(negedge clk);
    chk(req_ready && !swclk && !swdio_oe, "R12", "idle after traffic",
        {61'd0, req_ready, swclk, swdio_oe}, 64'h4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule